// File: doc/BRIEF.md
# Multi-Source Reset Timeout Supervisor

This block drives the active-low reset of a processor from a set of health conditions. The conditions are one power-good flag per sequenced rail, an enable flag, an active-low shutdown request, an active-low shared fault line, and a flag from the power sequencer that is high while a power-down is running. If any condition is bad, the reset is asserted. The reset is released only after every condition has stayed good without a break for a chosen number of clock cycles.

Three hold periods are available, each one a parameter given in cycles. The first is a long fixed period; with the default parameters it is about 128 ms at 125 MHz. The second is a short period of about 10 µs. The third is a count supplied on a port. A 2-bit mode input picks among them, and the block loads the chosen period only while the reset is asserted.

The block also reports whether the hold timer is running. It is a fully synchronous design. Analog timing and open-drain output drivers belong outside it.

Top module: `rst_timeout_sup`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first edge after it, `proc_rst_n` is 0 and `hold_busy` is 0. After reset, the selected period is the long one.
- R2: If at a clock edge any rail flag is 0, or `enable_ok` is 0, or `shdn_n` is 0, or `fault_n` is 0, then `proc_rst_n` is 0 after that edge.
- R3: If `pwrdn_active` is 1 at an edge, `proc_rst_n` is 0 after that edge, even when every other condition is good. This means a power-down asserts reset at once, without waiting for the rails to fall.
- R4: Suppose all conditions are good at P consecutive edges while reset is asserted, where P is the selected period. Then `proc_rst_n` rises after the P-th of those edges, and not before.
- R5: If any condition goes bad while the hold timer is counting, the count returns to zero and `hold_busy` falls after that edge. Counting restarts from zero at the next good edge.
- R6: Mode encoding is: 2'b00 selects LONG_CYCLES, 2'b01 selects SHORT_CYCLES, 2'b10 selects `prog_cycles` (a value of 0 is treated as 1), and 2'b11 selects SHORT_CYCLES. Mode and `prog_cycles` are loaded at each edge where `proc_rst_n` is 0. The loaded period applies from the following edge. Values presented while `proc_rst_n` is 1 have no effect.
- R7: `hold_busy` is 1 exactly when the hold count is nonzero. It is never 1 while `proc_rst_n` is 1.
- R8: Once released, `proc_rst_n` stays 1 for as long as all conditions remain good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the logic |
| rail_good | input | N_RAILS | Per-rail power-good flags, 1 = rail above threshold |
| enable_ok | input | 1 | Enable flag, 1 = enabled |
| shdn_n | input | 1 | Shutdown request, active low |
| fault_n | input | 1 | Shared fault line, active low |
| pwrdn_active | input | 1 | High while the sequencer is powering down |
| tmo_mode | input | 2 | Hold period select (see R6) |
| prog_cycles | input | CNT_W | Programmed hold period in cycles |
| proc_rst_n | output | 1 | Processor reset, active low, registered |
| hold_busy | output | 1 | Hold timer running, registered |

## Verification
Some properties are checked by assertions on every cycle. A bad condition forces reset low at the next edge. A power-down flag does the same. A release is always preceded by a good edge. While conditions are good, a released reset stays released. The busy flag never shows while reset is released. The loaded period stays frozen while reset is released.

Other properties only the bench scenarios can show. These are the exact release cycle for each mode, the handling of a programmed count of zero or one, the restart of the count after a glitch in the middle of counting, and the fact that a mode change while released has no effect. The bench shows these by comparing outputs with a cycle model, both in directed cases and under random condition glitches.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [1:0] {
    TMO_LONG  = 2'b00,
    TMO_SHORT = 2'b01,
    TMO_PROG  = 2'b10,
    TMO_ALT   = 2'b11
  } tmo_mode_e;

endpackage

// File: rtl/rsv_cond_gate.sv
module rsv_cond_gate #(
  parameter int N_RAILS = 4
) (
  input  logic [N_RAILS-1:0] rail_good,
  input  logic               enable_ok,
  input  logic               shdn_n,
  input  logic               fault_n,
  input  logic               pwrdn_active,
  output logic               all_ok
);

  logic [N_RAILS:0] rail_chain;

  assign rail_chain[0] = 1'b1;

  genvar gi;
  generate
    for (gi = 0; gi < N_RAILS; gi++) begin : g_rail
      assign rail_chain[gi+1] = rail_chain[gi] & rail_good[gi];
    end
  endgenerate

  always_comb begin
    all_ok = rail_chain[N_RAILS] & enable_ok & shdn_n & fault_n & ~pwrdn_active;
  end

endmodule

// File: rtl/rsv_period_sel.sv
module rsv_period_sel
  import rsv_pkg::*;
#(
  parameter int CNT_W        = 24,
  parameter int LONG_CYCLES  = 16000000,
  parameter int SHORT_CYCLES = 1250
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] prog_cycles,
  output logic [CNT_W-1:0] period_m1
);

  localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_CYCLES - 1);
  localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_CYCLES - 1);

  logic [CNT_W-1:0] next_m1;

  always_comb begin
    case (tmo_mode_e'(mode))
      TMO_LONG:  next_m1 = LONG_M1;
      TMO_SHORT: next_m1 = SHORT_M1;
      TMO_PROG:  next_m1 = (prog_cycles == '0) ? '0 : prog_cycles - 1'b1;
      default:   next_m1 = SHORT_M1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_m1 <= LONG_M1;
    end else if (load_en) begin
      period_m1 <= next_m1;
    end
  end

  // R6: period frozen while the reset output is released
  assert_period_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(period_m1));

endmodule

// File: rtl/rsv_timeout_ctr.sv
module rsv_timeout_ctr #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             all_ok,
  input  logic [CNT_W-1:0] period_m1,
  output logic             rst_n_q,
  output logic             busy_q
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             rst_n_nxt;

  always_comb begin
    cnt_nxt   = cnt_q;
    rst_n_nxt = rst_n_q;
    if (!all_ok) begin
      cnt_nxt   = '0;
      rst_n_nxt = 1'b0;
    end else if (!rst_n_q) begin
      if (cnt_q == period_m1) begin
        cnt_nxt   = '0;
        rst_n_nxt = 1'b1;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      rst_n_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      rst_n_q <= rst_n_nxt;
      busy_q  <= (cnt_nxt != '0);
    end
  end

  assert_bad_asserts_R2: assert property (@(posedge clk) disable iff (rst)
    !all_ok |=> !rst_n_q);

  assert_release_after_good_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_q) |-> $past(all_ok));

  assert_glitch_clears_R5: assert property (@(posedge clk) disable iff (rst)
    !all_ok |=> !busy_q);

  assert_busy_only_held_R7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !rst_n_q);

  assert_stays_released_R8: assert property (@(posedge clk) disable iff (rst)
    (rst_n_q && all_ok) |=> rst_n_q);

endmodule

// File: rtl/rst_timeout_sup.sv
module rst_timeout_sup #(
  parameter int N_RAILS      = 4,
  parameter int CNT_W        = 24,
  parameter int LONG_CYCLES  = 16000000,
  parameter int SHORT_CYCLES = 1250
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_RAILS-1:0] rail_good,
  input  logic               enable_ok,
  input  logic               shdn_n,
  input  logic               fault_n,
  input  logic               pwrdn_active,
  input  logic [1:0]         tmo_mode,
  input  logic [CNT_W-1:0]   prog_cycles,
  output logic               proc_rst_n,
  output logic               hold_busy
);

  logic             all_ok;
  logic [CNT_W-1:0] period_m1;
  logic             rst_n_int;
  logic             busy_int;

  rsv_cond_gate #(.N_RAILS(N_RAILS)) u_gate (
    .rail_good    (rail_good),
    .enable_ok    (enable_ok),
    .shdn_n       (shdn_n),
    .fault_n      (fault_n),
    .pwrdn_active (pwrdn_active),
    .all_ok       (all_ok)
  );

  rsv_period_sel #(
    .CNT_W        (CNT_W),
    .LONG_CYCLES  (LONG_CYCLES),
    .SHORT_CYCLES (SHORT_CYCLES)
  ) u_period (
    .clk         (clk),
    .rst         (rst),
    .load_en     (~rst_n_int),
    .mode        (tmo_mode),
    .prog_cycles (prog_cycles),
    .period_m1   (period_m1)
  );

  rsv_timeout_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .all_ok    (all_ok),
    .period_m1 (period_m1),
    .rst_n_q   (rst_n_int),
    .busy_q    (busy_int)
  );

  assign proc_rst_n = rst_n_int;
  assign hold_busy  = busy_int;

  assert_pwrdn_asserts_R3: assert property (@(posedge clk) disable iff (rst)
    pwrdn_active |=> !proc_rst_n);

endmodule

// File: tb/rst_timeout_sup_bench.sv
module rst_timeout_sup_bench;

  localparam int NR  = 4;
  localparam int CW  = 16;
  localparam int LNG = 600;
  localparam int SHT = 24;

  logic          clk = 1'b0;
  logic          rst;
  logic [NR-1:0] rail_good;
  logic          enable_ok, shdn_n, fault_n, pwrdn_active;
  logic [1:0]    tmo_mode;
  logic [CW-1:0] prog_cycles;
  logic          proc_rst_n, hold_busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  // bench cycle model
  bit exp_rn;
  int run;
  int per;

  always #4 clk = ~clk;

  rst_timeout_sup #(
    .N_RAILS(NR), .CNT_W(CW), .LONG_CYCLES(LNG), .SHORT_CYCLES(SHT)
  ) u_rst_timeout_sup (
    .clk(clk), .rst(rst), .rail_good(rail_good), .enable_ok(enable_ok),
    .shdn_n(shdn_n), .fault_n(fault_n), .pwrdn_active(pwrdn_active),
    .tmo_mode(tmo_mode), .prog_cycles(prog_cycles),
    .proc_rst_n(proc_rst_n), .hold_busy(hold_busy)
  );

  function automatic int period_of(logic [1:0] m, logic [CW-1:0] p);
    case (m)
      2'b00: return LNG;
      2'b01: return SHT;
      2'b10: return (p == 0) ? 1 : int'(p);
      default: return SHT;
    endcase
  endfunction

  function automatic bit conds_ok();
    return (&rail_good) && enable_ok && shdn_n && fault_n && !pwrdn_active;
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    int old_per;
    @(posedge clk);
    old_per = per;
    if (rst) begin
      exp_rn = 0; run = 0; per = LNG;
    end else begin
      if (!exp_rn) per = period_of(tmo_mode, prog_cycles);
      if (!conds_ok()) begin
        exp_rn = 0; run = 0;
      end else if (!exp_rn) begin
        run++;
        if (run >= old_per) begin exp_rn = 1; run = 0; end
      end
    end
    @(negedge clk);
    check(cur_req, proc_rst_n, exp_rn, "proc_rst_n");
    check(cur_req, hold_busy, (run != 0), "hold_busy");
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic all_good();
    rail_good = '1; enable_ok = 1; shdn_n = 1; fault_n = 1; pwrdn_active = 0;
  endtask

  // brings the block to released state with short period
  task automatic release_short();
    cur_req = "R4";
    fault_n = 0; tmo_mode = 2'b01; step(); step();
    all_good();
    steps(SHT + 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    rst = 1; all_good(); tmo_mode = 2'b01; prog_cycles = 5;
    exp_rn = 0; run = 0; per = LNG;
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    steps(3);
    rst = 0;
    step();

    // R4: short period release exact cycle (mode loaded during reset hold)
    cur_req = "R4";
    fault_n = 0; step(); step();
    all_good();
    steps(SHT - 1);
    check("R4", proc_rst_n, 1'b0, "one edge before release");
    step();
    check("R4", proc_rst_n, 1'b1, "release at period");
    steps(4);

    // R8: stays released
    cur_req = "R8";
    steps(50);

    // R6: mode change while released has no effect
    cur_req = "R6";
    tmo_mode = 2'b10; prog_cycles = 2;
    steps(5);
    check("R6", proc_rst_n, 1'b1, "ignored mode while released");

    // R2: each source individually
    cur_req = "R2";
    for (int k = 0; k < NR; k++) begin
      release_short();
      cur_req = "R2";
      rail_good[k] = 0; step();
      check("R2", proc_rst_n, 1'b0, "rail drop");
      all_good();
    end
    release_short(); cur_req = "R2"; enable_ok = 0; step(); all_good();
    release_short(); cur_req = "R2"; shdn_n = 0; step(); all_good();
    release_short(); cur_req = "R2"; fault_n = 0; step(); all_good();

    // R3: power-down flag alone
    release_short(); cur_req = "R3";
    pwrdn_active = 1; step();
    check("R3", proc_rst_n, 1'b0, "power-down asserts");
    steps(3); all_good();

    // R5: glitch during count
    cur_req = "R5";
    tmo_mode = 2'b01; fault_n = 0; step(); step(); all_good();
    steps(10);
    check("R7", hold_busy, 1'b1, "busy while counting");
    shdn_n = 0; step();
    check("R5", hold_busy, 1'b0, "count cleared");
    shdn_n = 1;
    steps(SHT - 1);
    check("R5", proc_rst_n, 1'b0, "restart from zero");
    step();
    check("R5", proc_rst_n, 1'b1, "release after restart");

    // R6: programmed periods 5, 1, 0
    cur_req = "R6";
    for (int v = 0; v < 3; v++) begin
      prog_cycles = (v == 0) ? 5 : (v == 1) ? 1 : 0;
      tmo_mode = 2'b10; enable_ok = 0; step(); step(); all_good();
      steps(8);
      check("R6", proc_rst_n, 1'b1, "programmed release");
    end
    // R6: mode 3 maps to short, mode 0 long
    tmo_mode = 2'b11; fault_n = 0; step(); step(); all_good(); steps(SHT + 1);
    tmo_mode = 2'b00; fault_n = 0; step(); step(); all_good();
    steps(LNG - 1);
    check("R6", proc_rst_n, 1'b0, "long not yet");
    step();
    check("R6", proc_rst_n, 1'b1, "long released");

    // random mix
    cur_req = "R5";
    for (int c = 0; c < 6000; c++) begin
      if (($urandom % 150) == 0) begin
        case ($urandom % 6)
          0: rail_good[$urandom % NR] = 0;
          1: enable_ok = 0;
          2: shdn_n = 0;
          3: fault_n = 0;
          4: pwrdn_active = 1;
          default: begin tmo_mode = 2'($urandom % 4); prog_cycles = CW'($urandom % 40); end
        endcase
      end else if (($urandom % 3) == 0) begin
        all_good();
      end
      if (tmo_mode == 2'b00 && ($urandom % 4) != 0) tmo_mode = 2'b01;
      step();
    end

    // R1: reset mid-run
    cur_req = "R1";
    rst = 1; steps(2); rst = 0; all_good();
    step();
    check("R1", proc_rst_n, 1'b0, "after reset");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule